// File: doc/BRIEF.md
# Transponder Read-Stream Terminator Sequencer

This block drives the uplink of a passive transponder. It reads 32-bit words from a small block store and sends them out one bit period at a time, most significant bit first. On every field clock it drives a damping (modulation) control line. A pass through the stream can begin with a fixed synchronization pattern, the terminator. A reader uses this pattern to find where the data begins. The terminator is four bit periods long. In some of those periods the gating is deliberately switched so that the pattern cannot be mistaken for data. The gating is inverted when Manchester coding is selected.

In regular streaming, each pass sends blocks 1 to the configured upper block number and then starts again. A single-block read request changes this: each pass then carries only the addressed block, with the terminator placed ahead of it. Setting the upper block number to 0 or 1 has the same effect as a single-block read. A stream boundary is the one idle clock between two passes. The configuration and any pending request are taken only at that boundary, so a change never lands in the middle of a bit. A write port fills the store. It stands in for the nonvolatile memory, which lies outside this block.

Top module: `rfid_stream_seq`

## Requirements
- R1: Each bit period lasts CLKS_PER_BIT field clocks. `bit_start` is high on the first clock of every period, terminator periods included. Passes are separated by exactly one idle clock. On that clock `mod_on`, `bit_start`, `term_active` and `data_bit` are all low.
- R2: When the terminator is produced, it fills the first four bit periods of a pass. `term_active` is high on every clock of those periods and `data_bit` reads 1 throughout.
- R3: For a non-Manchester type, the terminator drives `mod_on` high for all of its first and third periods and low for all of its second and fourth periods.
- R4: For Manchester (`cfg_mod_type` = 0), the terminator holds `mod_on` high for all of its second and fourth periods. In its first and third periods it carries a Manchester-coded 1: high for the first CLKS_PER_BIT/2 clocks, low for the rest.
- R5: The terminator appears only when `cfg_term_en` = 1 and `cfg_ext_mode` = 0. In every other case the pass starts directly with data.
- R6: When `cfg_mod_type` is 2 (bi-phase) or 3 (PSK), no terminator is produced, even if it is enabled. Type 1 is FSK.
- R7: In regular mode with `cfg_maxblk` ≥ 2, each pass sends blocks 1 to `cfg_maxblk` in ascending order, 32 bits each, MSB first. Passes repeat without end.
- R8: With `cfg_maxblk` = 0 a pass carries only block 0. With `cfg_maxblk` = 1 a pass carries only block 1. In both cases the terminator, when enabled, comes before the block.
- R9: A request with `req_single` = 1 makes every following pass carry only block `req_addr`, with the terminator ahead of it. A request with `req_single` = 0 returns the stream to regular mode.
- R10: Configuration inputs and requests are sampled only on the idle clock between passes. A change made during a pass does not alter that pass.
- R11: Data bits under Manchester drive `mod_on` to the bit value for the first half of the period and to its inverse for the second half. Under other types, `mod_on` equals the bit for the whole period. `data_bit` always shows the bit being sent.
- R12: While `rst_n` is low at a clock edge, all outputs go low and the block-read mode is cleared. The first clock after reset is an idle boundary clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_term_en | input | 1 | Terminator enable |
| cfg_ext_mode | input | 1 | Extended-mode flag; 1 bars the terminator |
| cfg_maxblk | input | ADDR_W | Highest block of a regular pass |
| cfg_mod_type | input | 2 | 0 Manchester, 1 FSK, 2 bi-phase, 3 PSK |
| req_valid | input | 1 | One-clock read request strobe |
| req_single | input | 1 | 1 single-block read, 0 back to regular |
| req_addr | input | ADDR_W | Block to read in single-block mode |
| wr_en | input | 1 | Block store write strobe |
| wr_addr | input | ADDR_W | Block store write address |
| wr_data | input | BLK_BITS | Block store write word |
| mod_on | output | 1 | Damping control, per field clock |
| bit_start | output | 1 | First clock of a bit period |
| term_active | output | 1 | Terminator in progress |
| data_bit | output | 1 | Underlying bit value of the current period |
| blk_num | output | ADDR_W | Block currently being sent |

## Verification
The bench builds the block with CLKS_PER_BIT = 8, so a bit period is 8 clocks and the Manchester half-period split falls after clock 4. It keeps eight 32-bit blocks. With these values a full pass of blocks 1 to 3 takes about 800 clocks. That lets the run reach every modulation type, upper block numbers 0, 1, 2 and 3, and several single-block reads. It also covers mid-pass changes to the configuration, and each of these is seen over at least two consecutive passes.

// File: rtl/rfid_seq_pkg.sv
// Package: shared types for the read-stream sequencer.
// Assumes a 2-bit modulation type code whose four values are all legal.
package rfid_seq_pkg;

    typedef enum logic [1:0] {
        MOD_MANCH = 2'd0,
        MOD_FSK   = 2'd1,
        MOD_BIPH  = 2'd2,
        MOD_PSK   = 2'd3
    } mod_type_e;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_TERM = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam int TERM_PERIODS = 4;

endpackage

// File: rtl/rfid_blk_store.sv
// Block store: NUM_BLK words of BLK_BITS, one register bank per word.
// Read is combinational and returns one bit, selected MSB-first by bit index.
// Assumes NUM_BLK is a power of two so every address is a valid word.
module rfid_blk_store #(
    parameter int BLK_BITS  = 32,
    parameter int NUM_BLK   = 8,
    parameter int ADDR_W    = $clog2(NUM_BLK),
    parameter int BIT_IDX_W = $clog2(BLK_BITS)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BLK_BITS-1:0]  wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [BIT_IDX_W-1:0] rd_bit_idx,
    output logic                 rd_bit
);

    localparam logic [BIT_IDX_W-1:0] TOP_BIT = BIT_IDX_W'(BLK_BITS - 1);

    logic [BLK_BITS-1:0] words [NUM_BLK];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_word
        // Load one word when its address is written.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == ADDR_W'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    // Select the current bit, MSB first.
    always_comb begin
        rd_bit = words[rd_addr][TOP_BIT - rd_bit_idx];
    end

endmodule

// File: rtl/rfid_bit_timer.sv
// Bit-period timer: counts field clocks within a bit period while running.
// Held at zero when idle, so the first running clock starts a period.
// Assumes CLKS_PER_BIT is even and at least 2.
module rfid_bit_timer #(
    parameter int CLKS_PER_BIT = 32,
    parameter int CNT_W        = $clog2(CLKS_PER_BIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bit_first,
    output logic bit_last,
    output logic second_half
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(CLKS_PER_BIT / 2);

    logic [CNT_W-1:0] cnt;

    // Advance the clock-within-bit counter, wrapping each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Period markers derived from the counter.
    always_comb begin
        bit_first   = run && (cnt == '0);
        bit_last    = run && (cnt == LAST_CNT);
        second_half = (cnt >= HALF_CNT);
    end

endmodule

// File: rtl/rfid_pass_ctrl.sv
// Pass controller: decides the content of each pass and walks it.
// On the single idle clock between passes it samples configuration and any
// pending request, picks the block range and whether a terminator leads,
// then steps through terminator periods and data bits on bit_last.
// Assumes requests are one-clock strobes; the latest one before a boundary wins.
module rfid_pass_ctrl
    import rfid_seq_pkg::*;
#(
    parameter int BLK_BITS  = 32,
    parameter int ADDR_W    = 3,
    parameter int BIT_IDX_W = $clog2(BLK_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_last,
    input  logic                 cfg_term_en,
    input  logic                 cfg_ext_mode,
    input  logic [ADDR_W-1:0]    cfg_maxblk,
    input  mod_type_e            cfg_mod_type,
    input  logic                 req_valid,
    input  logic                 req_single,
    input  logic [ADDR_W-1:0]    req_addr,
    output phase_e               phase,
    output logic [1:0]           term_idx,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic [ADDR_W-1:0]    blk_cur,
    output mod_type_e            pass_mt
);

    localparam logic [BIT_IDX_W-1:0] LAST_BIT  = BIT_IDX_W'(BLK_BITS - 1);
    localparam logic [1:0]           LAST_TERM = 2'(TERM_PERIODS - 1);

    logic              pend_valid;
    logic              pend_single;
    logic [ADDR_W-1:0] pend_addr;
    logic              cur_single;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] blk_last;

    logic              eff_single;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] first_blk;
    logic [ADDR_W-1:0] last_blk;
    logic              term_ok;

    // Hold the most recent request until the next pass boundary consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid  <= 1'b0;
            pend_single <= 1'b0;
            pend_addr   <= '0;
        end else if (req_valid) begin
            pend_valid  <= 1'b1;
            pend_single <= req_single;
            pend_addr   <= req_addr;
        end else if (phase == PH_LOAD) begin
            pend_valid  <= 1'b0;
        end
    end

    // Work out the next pass: mode, block range and terminator permission.
    always_comb begin
        eff_single = pend_valid ? pend_single : cur_single;
        eff_addr   = pend_valid ? pend_addr   : cur_addr;
        if (eff_single) begin
            first_blk = eff_addr;
            last_blk  = eff_addr;
        end else if (cfg_maxblk == '0) begin
            first_blk = '0;
            last_blk  = '0;
        end else begin
            first_blk = ADDR_W'(1);
            last_blk  = cfg_maxblk;
        end
        term_ok = cfg_term_en && !cfg_ext_mode &&
                  ((cfg_mod_type == MOD_MANCH) || (cfg_mod_type == MOD_FSK));
    end

    // Step through boundary, terminator periods and data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_LOAD;
            term_idx   <= '0;
            bit_idx    <= '0;
            blk_cur    <= '0;
            blk_last   <= '0;
            pass_mt    <= MOD_MANCH;
            cur_single <= 1'b0;
            cur_addr   <= '0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    cur_single <= eff_single;
                    cur_addr   <= eff_addr;
                    blk_cur    <= first_blk;
                    blk_last   <= last_blk;
                    pass_mt    <= cfg_mod_type;
                    term_idx   <= '0;
                    bit_idx    <= '0;
                    phase      <= term_ok ? PH_TERM : PH_DATA;
                end
                PH_TERM: begin
                    if (bit_last) begin
                        if (term_idx == LAST_TERM) begin
                            phase <= PH_DATA;
                        end else begin
                            term_idx <= term_idx + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (bit_last) begin
                        if (bit_idx == LAST_BIT) begin
                            bit_idx <= '0;
                            if (blk_cur == blk_last) begin
                                phase <= PH_LOAD;
                            end else begin
                                blk_cur <= blk_cur + 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/rfid_mod_shaper.sv
// Modulation shaper: turns phase, terminator period and data bit into the
// per-clock damping level, applying the Manchester half-period split.
// Assumes second_half comes from the bit timer of the same period.
module rfid_mod_shaper
    import rfid_seq_pkg::*;
(
    input  phase_e     phase,
    input  logic [1:0] term_idx,
    input  mod_type_e  pass_mt,
    input  logic       blk_bit,
    input  logic       second_half,
    output logic       mod_on,
    output logic       data_bit
);

    logic manch;

    // Produce damping level and underlying bit for the current clock.
    always_comb begin
        manch    = (pass_mt == MOD_MANCH);
        mod_on   = 1'b0;
        data_bit = 1'b0;
        case (phase)
            PH_TERM: begin
                data_bit = 1'b1;
                if (term_idx[0]) begin
                    mod_on = manch;
                end else begin
                    mod_on = manch ? !second_half : 1'b1;
                end
            end
            PH_DATA: begin
                data_bit = blk_bit;
                mod_on   = manch ? (blk_bit ^ second_half) : blk_bit;
            end
            default: begin
                mod_on   = 1'b0;
                data_bit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rfid_stream_seq.sv
// Top: read-stream sequencer with synchronization terminator.
// Ties the block store, bit timer, pass controller and shaper together.
// Assumes NUM_BLK is a power of two and CLKS_PER_BIT is even and >= 2.
module rfid_stream_seq
    import rfid_seq_pkg::*;
#(
    parameter int CLKS_PER_BIT = 32,
    parameter int BLK_BITS     = 32,
    parameter int NUM_BLK      = 8,
    parameter int ADDR_W       = $clog2(NUM_BLK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_term_en,
    input  logic                cfg_ext_mode,
    input  logic [ADDR_W-1:0]   cfg_maxblk,
    input  logic [1:0]          cfg_mod_type,
    input  logic                req_valid,
    input  logic                req_single,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BLK_BITS-1:0] wr_data,
    output logic                mod_on,
    output logic                bit_start,
    output logic                term_active,
    output logic                data_bit,
    output logic [ADDR_W-1:0]   blk_num
);

    localparam int BIT_IDX_W = $clog2(BLK_BITS);
    localparam int CNT_W     = $clog2(CLKS_PER_BIT);

    phase_e               pass_phase;
    logic [1:0]           term_idx;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [ADDR_W-1:0]    blk_cur;
    mod_type_e            pass_mt;
    logic                 bit_first;
    logic                 bit_last;
    logic                 second_half;
    logic                 blk_bit;
    logic                 timer_run;

    assign timer_run = (pass_phase != PH_LOAD);

    rfid_blk_store #(
        .BLK_BITS  (BLK_BITS),
        .NUM_BLK   (NUM_BLK),
        .ADDR_W    (ADDR_W),
        .BIT_IDX_W (BIT_IDX_W)
    ) u_store (
        .clk        (clk),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (blk_cur),
        .rd_bit_idx (bit_idx),
        .rd_bit     (blk_bit)
    );

    rfid_bit_timer #(
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .CNT_W        (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (timer_run),
        .bit_first   (bit_first),
        .bit_last    (bit_last),
        .second_half (second_half)
    );

    rfid_pass_ctrl #(
        .BLK_BITS  (BLK_BITS),
        .ADDR_W    (ADDR_W),
        .BIT_IDX_W (BIT_IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_last     (bit_last),
        .cfg_term_en  (cfg_term_en),
        .cfg_ext_mode (cfg_ext_mode),
        .cfg_maxblk   (cfg_maxblk),
        .cfg_mod_type (mod_type_e'(cfg_mod_type)),
        .req_valid    (req_valid),
        .req_single   (req_single),
        .req_addr     (req_addr),
        .phase        (pass_phase),
        .term_idx     (term_idx),
        .bit_idx      (bit_idx),
        .blk_cur      (blk_cur),
        .pass_mt      (pass_mt)
    );

    rfid_mod_shaper u_shaper (
        .phase       (pass_phase),
        .term_idx    (term_idx),
        .pass_mt     (pass_mt),
        .blk_bit     (blk_bit),
        .second_half (second_half),
        .mod_on      (mod_on),
        .data_bit    (data_bit)
    );

    // Drive the status outputs from the controller state.
    always_comb begin
        bit_start   = bit_first;
        term_active = (pass_phase == PH_TERM);
        blk_num     = blk_cur;
    end

endmodule

// File: rtl/rfid_stream_seq_chk.sv
// Checker: temporal properties of the sequencer, bound into the top.
// Assumes synchronous active-low reset; all properties disabled in reset.
module rfid_stream_seq_chk
    import rfid_seq_pkg::*;
#(
    parameter int CLKS_PER_BIT = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mod_on,
    input logic       bit_start,
    input logic       term_active,
    input logic       data_bit,
    input phase_e     phase,
    input logic [1:0] term_idx,
    input mod_type_e  pass_mt
);

    int unsigned run_len;

    // Count consecutive terminator clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !term_active) begin
            run_len <= 0;
        end else begin
            run_len <= run_len + 1;
        end
    end

    assert_term_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(term_active) |-> (run_len == 32'(TERM_PERIODS * CLKS_PER_BIT)));

    assert_term_data_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        term_active |-> data_bit);

    assert_bit_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |=> !bit_start);

    assert_boundary_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) |-> (!mod_on && !bit_start && !term_active));

    assert_term_gate_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (term_active && (pass_mt != MOD_MANCH) && term_idx[0]) |-> !mod_on);

    assert_term_gate_manch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (term_active && (pass_mt == MOD_MANCH) && term_idx[0]) |-> mod_on);

    assert_term_type_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        term_active |-> ((pass_mt == MOD_MANCH) || (pass_mt == MOD_FSK)));

    assert_reset_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mod_on && !bit_start && !term_active));

endmodule

bind rfid_stream_seq rfid_stream_seq_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_on      (mod_on),
    .bit_start   (bit_start),
    .term_active (term_active),
    .data_bit    (data_bit),
    .phase       (pass_phase),
    .term_idx    (term_idx),
    .pass_mt     (pass_mt)
);

// File: tb/rfid_stream_seq_tb.sv
`timescale 1ns/1ps
module rfid_stream_seq_tb;

    localparam int CPB    = 8;
    localparam int NBLK   = 8;
    localparam int AW     = 3;
    localparam int WB     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_term_en = 1'b0;
    logic          cfg_ext_mode = 1'b0;
    logic [AW-1:0] cfg_maxblk = '0;
    logic [1:0]    cfg_mod_type = 2'd1;
    logic          req_valid = 1'b0;
    logic          req_single = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WB-1:0] wr_data = '0;
    logic          mod_on, bit_start, term_active, data_bit;
    logic [AW-1:0] blk_num;

    rfid_stream_seq #(
        .CLKS_PER_BIT (CPB),
        .BLK_BITS     (WB),
        .NUM_BLK      (NBLK)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_term_en (cfg_term_en), .cfg_ext_mode (cfg_ext_mode),
        .cfg_maxblk (cfg_maxblk), .cfg_mod_type (cfg_mod_type),
        .req_valid (req_valid), .req_single (req_single), .req_addr (req_addr),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .mod_on (mod_on), .bit_start (bit_start), .term_active (term_active),
        .data_bit (data_bit), .blk_num (blk_num)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int pass_cnt = 0;
    int cycles = 0;
    int term_seen = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic       mod;
        logic       bs;
        logic       term;
        logic       dat;
        logic [3:0] tmod;
        logic [3:0] toth;
    } exp_t;

    exp_t          q[$];
    logic [WB-1:0] mem_m [NBLK];
    bit            pend_v = 0;
    bit            pend_s = 0;
    int            pend_a = 0;
    bit            cur_s = 0;
    int            cur_a = 0;

    function automatic string tag_name(input int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cycles);
        end
    endtask

    // Build the expected per-clock stream of one pass from the sampled inputs.
    task automatic build_pass();
        bit single;
        int addr, mt, first_b, last_b, kind, sup;
        bit manch, term;
        exp_t e;
        single = pend_v ? pend_s : cur_s;
        addr   = pend_v ? pend_a : cur_a;
        pend_v = 0;
        cur_s  = single;
        cur_a  = addr;
        mt     = int'(cfg_mod_type);
        manch  = (mt == 0);
        term   = cfg_term_en && !cfg_ext_mode && (mt < 2);
        if (single) begin first_b = addr; last_b = addr; kind = 9; end
        else if (cfg_maxblk == 0) begin first_b = 0; last_b = 0; kind = 8; end
        else if (cfg_maxblk == 1) begin first_b = 1; last_b = 1; kind = 8; end
        else begin first_b = 1; last_b = int'(cfg_maxblk); kind = 7; end
        sup = term ? kind : ((cfg_term_en && !cfg_ext_mode) ? 6 : 5);
        if (term) begin
            for (int k = 0; k < 4; k++) begin
                for (int c = 0; c < CPB; c++) begin
                    e.bs = (c == 0); e.term = 1'b1; e.dat = 1'b1;
                    if (k % 2 == 1) e.mod = manch;
                    else            e.mod = manch ? (c < CPB/2) : 1'b1;
                    e.tmod = manch ? 4'd4 : 4'd3;
                    e.toth = 4'd2;
                    q.push_back(e);
                end
            end
        end
        for (int b = first_b; b <= last_b; b++) begin
            for (int i = WB-1; i >= 0; i--) begin
                for (int c = 0; c < CPB; c++) begin
                    logic bv;
                    bv     = mem_m[b][i];
                    e.bs   = (c == 0);
                    e.term = 1'b0;
                    e.dat  = bv;
                    e.mod  = manch ? ((c < CPB/2) ? bv : !bv) : bv;
                    e.tmod = 4'd11;
                    e.toth = (b == first_b && i == WB-1) ? 4'(sup) : 4'(kind);
                    q.push_back(e);
                end
            end
        end
    endtask

    // Reference model: compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            if (term_active === 1'b1) term_seen++;
            if (rst_n) begin
                exp_t e;
                if (q.size() == 0) begin
                    e = '{mod:1'b0, bs:1'b0, term:1'b0, dat:1'b0, tmod:4'd1, toth:4'd1};
                    pass_cnt++;
                    build_pass();
                end else begin
                    e = q.pop_front();
                end
                checks++;
                if (mod_on !== e.mod) begin
                    errors++;
                    $display("FAIL %s: mod_on actual=%0d expected=%0d at cycle %0d",
                             tag_name(int'(e.tmod)), mod_on, e.mod, cycles);
                end else if (bit_start !== e.bs) begin
                    errors++;
                    $display("FAIL R1: bit_start actual=%0d expected=%0d at cycle %0d",
                             bit_start, e.bs, cycles);
                end else if (term_active !== e.term || data_bit !== e.dat) begin
                    errors++;
                    $display("FAIL %s: term/data actual=%0d%0d expected=%0d%0d at cycle %0d",
                             tag_name(int'(e.toth)), term_active, data_bit, e.term, e.dat, cycles);
                end
                if (req_valid) begin
                    pend_v = 1; pend_s = req_single; pend_a = int'(req_addr);
                end
            end
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            finish_up();
        end
    end

    task automatic wait_passes(input int n);
        int target;
        target = pass_cnt + n;
        while (pass_cnt < target) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input bit en, input bit ext, input int mb, input int mt);
        @(posedge clk); #1;
        cfg_term_en = en; cfg_ext_mode = ext;
        cfg_maxblk = AW'(mb); cfg_mod_type = 2'(mt);
    endtask

    task automatic send_req(input bit single, input int addr);
        @(posedge clk); #1;
        req_valid = 1'b1; req_single = single; req_addr = AW'(addr);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Count terminator clocks over one whole pass that follows a new setting.
    task automatic expect_no_term(input string req);
        wait_passes(1);
        term_seen = 0;
        wait_passes(1);
        check(term_seen == 0, req, term_seen, 0);
    endtask

    initial begin
        // Reset and fill the block store (R12).
        for (int i = 0; i < NBLK; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1; wr_addr = AW'(i);
            wr_data = 32'hA5C3_0F96 ^ (32'h1357_9BDF * (i + 1));
            mem_m[i] = wr_data;
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
        cfg_term_en = 1'b1; cfg_mod_type = 2'd1; cfg_maxblk = 3'd3;
        @(negedge clk);
        check(mod_on == 0 && bit_start == 0 && term_active == 0 && data_bit == 0,
              "R12", {mod_on, bit_start, term_active, data_bit}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Regular FSK stream, terminator on (R2, R3, R7, R11).
        wait_passes(3);

        // Manchester, two blocks; disable terminator mid-terminator (R4, R10).
        set_cfg(1, 0, 2, 0);
        wait_passes(2);
        cfg_term_en = 1'b0;
        repeat (2*CPB) @(posedge clk);
        @(negedge clk);
        check(term_active == 1'b1, "R10", term_active, 1);
        wait_passes(1);
        @(negedge clk);
        check(term_active == 1'b0, "R10", term_active, 0);

        // Extended mode and disabled enable both suppress (R5).
        set_cfg(1, 1, 3, 1);
        expect_no_term("R5");
        set_cfg(0, 0, 3, 0);
        expect_no_term("R5");

        // Bi-phase and PSK suppress even when enabled (R6).
        set_cfg(1, 0, 2, 2);
        expect_no_term("R6");
        set_cfg(1, 0, 2, 3);
        expect_no_term("R6");

        // Upper block number 0 and 1 (R8).
        set_cfg(1, 0, 0, 1);
        wait_passes(3);
        set_cfg(1, 0, 1, 0);
        wait_passes(3);

        // Single-block reads and return to regular (R9).
        set_cfg(1, 0, 7, 1);
        wait_passes(1);
        send_req(1, 5);
        wait_passes(3);
        set_cfg(1, 0, 7, 0);
        send_req(1, 0);
        wait_passes(3);
        send_req(0, 0);
        set_cfg(1, 0, 2, 1);
        wait_passes(3);

        finish_up();
    end

endmodule